// File: doc/BRIEF.md
# Branch Target Buffer

This block sits beside instruction fetch. For the current fetch address it says, in the same cycle, whether the address belongs to a control instruction seen before and, if so, where that instruction is expected to go. Fetch takes the next address from `next_pc_o`. On a hit this is the stored target. On a miss it is the sequential address four bytes on.

Each entry holds a valid bit, a partial tag and a full target address. The entry index comes from the word address bits just above the byte offset. The tag keeps only the next few bits above the index. Two unrelated addresses that agree in those bits share an entry and both hit. This aliasing is accepted: a hit is only a guess, and a wrong guess is corrected later in the pipeline.

When a control instruction resolves, the pipeline writes its address and actual target through the update port. The write lands at the clock edge and replaces whatever the entry held.

Top module: `btb`

## Requirements
- R1: After reset, every entry is invalid, so every lookup misses until an update is written.
- R2: Bits [1:0] of an address are ignored. The index is bits [IDX_W+1:2] (default [9:2]). The tag is bits [IDX_W+TAG_W+1:IDX_W+2] (default [19:10]).
- R3: `hit_o` is 1 when the indexed entry is valid and its tag equals the lookup tag. On a hit, `target_o` equals the target written by the last update to that entry.
- R4: On a miss, `target_o` is zero.
- R5: `next_pc_o` equals `target_o` on a hit and `lookup_pc_i + 4` on a miss.
- R6: An update with `upd_en_i` high writes valid, tag and target at the rising clock edge. A lookup of the same address in the next cycle hits with that target.
- R7: If a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before the update.
- R8: Two addresses with the same index and tag bits hit the same entry, even when they differ in bits above the tag.
- R9: An update to an entry with a different tag replaces the old tag. The address that used to hit there then misses.
- R10: The lookup is combinational: `hit_o`, `target_o` and `next_pc_o` follow `lookup_pc_i` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_pc_i | input | PC_W | Fetch address to look up |
| hit_o | output | 1 | Entry valid and partial tag matched |
| target_o | output | PC_W | Predicted target on a hit, zero otherwise |
| next_pc_o | output | PC_W | Predicted next fetch address |
| upd_en_i | input | 1 | Write the update into the buffer |
| upd_pc_i | input | PC_W | Address of the resolved control instruction |
| upd_target_i | input | PC_W | Actual target of that instruction |

## Verification
The bench fills all 256 entries with distinct tags and odd low target bits. It then reads each one back with the offset bits set, so a design that let bits [1:0] reach the index or the tag would miss or return a neighbour's target. It flips a single tag bit to catch an incomplete compare, and it alters bits above the tag to show that aliasing hits. A design with a stale valid bit after a second reset would hit in that sweep. A lookup and an update to one entry in the same cycle must show the old target first and the new one only after the edge; a design that bypassed the write would show the new target early. Replacing an entry's tag must turn the old address into a miss whose next address is sequential.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned OFS_W      = 2;  // byte offset inside a 4-byte instruction
  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 10
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  import btb_pkg::*;
  localparam int unsigned TAG_LO = OFS_W + IDX_W;

  assign idx_o = pc_i[OFS_W +: IDX_W];
  assign tag_o = pc_i[TAG_LO +: TAG_W];
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_vld_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [PC_W-1:0]  rd_tgt_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_tgt_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q           <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= 1'b1;
  end

  // payload needs no reset: gated by vld_q
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      tgt_q[wr_idx_i] <= wr_tgt_i;
    end
  end

  // read before write: same-cycle update is seen only after the edge
  assign rd_vld_o = vld_q[rd_idx_i];
  assign rd_tag_o = tag_q[rd_idx_i];
  assign rd_tgt_o = tgt_q[rd_idx_i];
endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned TAG_W = 10
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [TAG_W-1:0] pc_tag_i,
  input  logic             ent_vld_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [PC_W-1:0]  ent_tgt_i,
  output logic             hit_o,
  output logic [PC_W-1:0]  target_o,
  output logic [PC_W-1:0]  next_pc_o
);
  import btb_pkg::*;
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  logic [PC_W-1:0] seq_pc;

  always_comb begin
    seq_pc    = pc_i + STEP;
    hit_o     = ent_vld_i && (ent_tag_i == pc_tag_i);
    target_o  = hit_o ? ent_tgt_i : '0;
    next_pc_o = hit_o ? ent_tgt_i : seq_pc;
  end
endmodule

// File: rtl/btb.sv
module btb #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lookup_pc_i,
  output logic            hit_o,
  output logic [PC_W-1:0] target_o,
  output logic [PC_W-1:0] next_pc_o,
  input  logic            upd_en_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic [PC_W-1:0] upd_target_i
);
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             ent_vld;
  logic [TAG_W-1:0] ent_tag;
  logic [PC_W-1:0]  ent_tgt;

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_split (
    .pc_i(lookup_pc_i), .idx_o(lk_idx), .tag_o(lk_tag)
  );

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_up_split (
    .pc_i(upd_pc_i), .idx_o(up_idx), .tag_o(up_tag)
  );

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (lk_idx),
    .rd_vld_o (ent_vld),
    .rd_tag_o (ent_tag),
    .rd_tgt_o (ent_tgt),
    .wr_en_i  (upd_en_i),
    .wr_idx_i (up_idx),
    .wr_tag_i (up_tag),
    .wr_tgt_i (upd_target_i)
  );

  btb_match #(.PC_W(PC_W), .TAG_W(TAG_W)) u_match (
    .pc_i      (lookup_pc_i),
    .pc_tag_i  (lk_tag),
    .ent_vld_i (ent_vld),
    .ent_tag_i (ent_tag),
    .ent_tgt_i (ent_tgt),
    .hit_o     (hit_o),
    .target_o  (target_o),
    .next_pc_o (next_pc_o)
  );
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] lookup_pc_i,
  input logic            hit_o,
  input logic [PC_W-1:0] target_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            upd_en_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic [PC_W-1:0] upd_target_i
);
  localparam int unsigned KEY_HI = IDX_W + TAG_W + 1;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> !hit_o);

  // R4
  miss_tgt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> target_o == '0);

  // R5
  miss_next_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> next_pc_o == lookup_pc_i + PC_W'(4));

  // R5
  hit_next_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> next_pc_o == target_o);

  // R6
  write_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(upd_en_i) &&
     lookup_pc_i[KEY_HI:2] == $past(upd_pc_i[KEY_HI:2]))
    |-> (hit_o && target_o == $past(upd_target_i)));
endmodule

bind btb btb_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/btb_tb.sv
`timescale 1ns/1ps
module btb_tb;
  localparam int unsigned PC_W  = 32;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned TAG_W = 10;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [PC_W-1:0] lookup_pc_i = '0;
  logic            hit_o;
  logic [PC_W-1:0] target_o, next_pc_o;
  logic            upd_en_i = 1'b0;
  logic [PC_W-1:0] upd_pc_i = '0, upd_target_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  btb #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_dut (.*);

  function automatic logic [TAG_W-1:0] tag_of(int i);
    return TAG_W'((i * 37 + 5) & 32'h3ff);
  endfunction

  function automatic logic [PC_W-1:0] mk_pc(int i, logic [TAG_W-1:0] t,
                                            logic [11:0] hi, logic [1:0] ofs);
    return {hi, t, i[7:0], ofs};
  endfunction

  function automatic logic [PC_W-1:0] tgt_of(int i);
    return 32'h4000_0000 + PC_W'(i * 64) + 32'd3;
  endfunction

  task automatic chk(bit ok, string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(logic [PC_W-1:0] pc, bit exp_hit, logic [PC_W-1:0] exp_tgt, string req);
    @(negedge clk_i);
    lookup_pc_i = pc;
    #2;
    chk(hit_o == exp_hit, {req, " hit"}, PC_W'(hit_o), PC_W'(exp_hit));
    chk(target_o == (exp_hit ? exp_tgt : '0), {req, " target"}, target_o,
        exp_hit ? exp_tgt : '0);
    chk(next_pc_o == (exp_hit ? exp_tgt : pc + 32'd4), {req, " next_pc"}, next_pc_o,
        exp_hit ? exp_tgt : pc + 32'd4);
  endtask

  task automatic wr(logic [PC_W-1:0] pc, logic [PC_W-1:0] tgt);
    @(negedge clk_i);
    upd_en_i = 1'b1; upd_pc_i = pc; upd_target_i = tgt;
    @(posedge clk_i);
    #1 upd_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: all entries empty after reset
    for (int i = 0; i < DEPTH; i++) look(mk_pc(i, tag_of(i), 12'h000, 2'b00), 1'b0, '0, "R1");

    // R6: fill every entry
    for (int i = 0; i < DEPTH; i++) wr(mk_pc(i, tag_of(i), 12'h000, 2'b00), tgt_of(i));

    for (int i = 0; i < DEPTH; i++) begin
      look(mk_pc(i, tag_of(i), 12'h000, 2'b00), 1'b1, tgt_of(i), "R3");
      look(mk_pc(i, tag_of(i), 12'h000, 2'b11), 1'b1, tgt_of(i), "R2");
      look(mk_pc(i, tag_of(i), 12'hA5C, 2'b01), 1'b1, tgt_of(i), "R8");
      look(mk_pc(i, tag_of(i) ^ TAG_W'(1 << (i % TAG_W)), 12'h000, 2'b00), 1'b0, '0, "R4");
    end

    // R10: output follows input within one cycle, no edge in between
    @(negedge clk_i);
    lookup_pc_i = mk_pc(3, tag_of(3), 12'h0, 2'b00);
    #1;
    chk(target_o == tgt_of(3), "R10 first", target_o, tgt_of(3));
    lookup_pc_i = mk_pc(4, tag_of(4), 12'h0, 2'b00);
    #1;
    chk(target_o == tgt_of(4), "R10 second", target_o, tgt_of(4));

    // R7: same-cycle lookup and update of entry 5
    @(negedge clk_i);
    lookup_pc_i  = mk_pc(5, tag_of(5), 12'h0, 2'b00);
    upd_en_i     = 1'b1;
    upd_pc_i     = mk_pc(5, tag_of(5), 12'h0, 2'b00);
    upd_target_i = 32'hDEAD_BEE0;
    #2;
    chk(target_o == tgt_of(5), "R7 old contents", target_o, tgt_of(5));
    @(posedge clk_i);
    #1 upd_en_i = 1'b0;
    #2;
    chk(hit_o && target_o == 32'hDEAD_BEE0, "R6 new contents", target_o, 32'hDEAD_BEE0);

    // R9: replace tag of entry 7
    wr(mk_pc(7, ~tag_of(7), 12'h0, 2'b00), 32'h0000_1230);
    look(mk_pc(7, tag_of(7), 12'h0, 2'b00), 1'b0, '0, "R9 old");
    look(mk_pc(7, ~tag_of(7), 12'h0, 2'b00), 1'b1, 32'h0000_1230, "R9 new");

    // R1: second reset wipes everything
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 0; i < DEPTH; i++) look(mk_pc(i, tag_of(i), 12'h000, 2'b00), 1'b0, '0, "R1 rerun");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule